// File: doc/BRIEF.md
# Vectored Interrupt Collector

The collector gathers up to `NSRC` level-sensitive interrupt lines and drives one registered request to the processor. Software enables each source through its own control register. It reads a status register to learn which source to serve, and the lowest-numbered source that is both pending and enabled is reported. Software then writes a level acknowledge once the handler is done.

Reading the status register while a source is pending puts level 0 in service. The processor request then stays low until the acknowledge arrives. Every register answers on a 16-byte slot at four word addresses: plain write, bit set, bit clear and bit toggle. Software can therefore change single bits without a read-modify-write. A soft-reset bit in the control register wipes all enables and the in-service state for as long as it stays set.

The register bus has separate write and read channels, each with its own strobe and address. A read and a write can therefore land in the same cycle. Read data is combinational from the read address.

Top module: `irq_collector`

## Requirements
- R1: Address bits [3:2] select how a write applies to the slot's register: 0 stores the data, 1 ORs it in, 2 clears the bits set in the data, and 3 inverts those bits. The vector register at slot 0x000 holds all 32 bits, and this applies to it too.
- R2: The control register for source n sits at byte address 0x120 + 0x10*n. Its bit 2 is the enable. It reads back as 0x4 when enabled and 0x0 when not, and all other bits read 0.
- R3: A read of address 0x070 returns the lowest-numbered source whose input is high and whose enable is set. When no such source exists, it returns the value NSRC (128 by default).
- R4: A source whose enable is clear never raises cpu_irq and is never reported in the status register.
- R5: cpu_irq is registered. A change on a source input, or an enable update that takes effect at a clock edge, shows on cpu_irq one clock edge later.
- R6: A status read taken while some source is reported puts the collector in service. From the second edge after that read, cpu_irq stays low until an acknowledge is accepted.
- R7: A write to address 0x010 whose data bit 0 is 1, at any of the four alias addresses, ends the in-service state. cpu_irq then returns one edge later if a source is still pending. This register reads 0.
- R8: If a status read that finds a pending source and an acknowledge write fall in the same cycle, the read wins and the collector stays in service.
- R9: Bit 31 of the control register at 0x020 is the soft-reset bit and follows the R1 alias rules. While it reads 1, every enable and the in-service state are forced clear, including enable writes made in that time. Enables stay clear after the bit is cleared.
- R10: After rst_n is asserted low, cpu_irq is 0 and the vector, control and every source control register read 0. The status register reads NSRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Level-sensitive interrupt inputs |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe (side effect on status reads only) |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| cpu_irq | output | 1 | Registered request to the processor |

## Verification
Two functions can coincide in one cycle: a status read that starts service and a level acknowledge that ends it. Because the read and write channels are separate, the bench drives both strobes in the same cycle while a source is pending and already in service. It judges the result by cpu_irq, which must stay low until a later, lone acknowledge brings it back. The same sweep also places enable writes inside a soft-reset window and checks through read-back that they are discarded.

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int NSRC   = 128,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              cpu_irq
);

  localparam int SLOT_W = ADDR_W - 4;
  localparam int IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int STAT_W = $clog2(NSRC + 1);
  localparam logic [SLOT_W-1:0] S_VEC  = SLOT_W'(0);
  localparam logic [SLOT_W-1:0] S_ACK  = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] S_CTRL = SLOT_W'(2);
  localparam logic [SLOT_W-1:0] S_STAT = SLOT_W'(7);
  localparam logic [SLOT_W-1:0] S_SRC0 = SLOT_W'(18);

  function automatic logic [31:0] apply_op(input logic [1:0] k,
                                           input logic [31:0] old, input logic [31:0] d);
    case (k)
      2'd0:    return d;
      2'd1:    return old | d;
      2'd2:    return old & ~d;
      default: return old ^ d;
    endcase
  endfunction

  logic [31:0]     vec_q;
  logic            srst_q;
  logic [NSRC-1:0] en_q;
  logic            in_svc_q;

  wire [SLOT_W-1:0] wslot = wr_addr[ADDR_W-1:4];
  wire [SLOT_W-1:0] rslot = rd_addr[ADDR_W-1:4];
  wire [1:0]        wop   = wr_addr[3:2];
  wire              w_src = (wslot >= S_SRC0) && (int'(wslot) - 18 < NSRC);
  wire              r_src = (rslot >= S_SRC0) && (int'(rslot) - 18 < NSRC);
  wire [IDX_W-1:0]  widx  = IDX_W'(wslot - S_SRC0);
  wire [IDX_W-1:0]  ridx  = IDX_W'(rslot - S_SRC0);

  wire [NSRC-1:0] live = src_i & en_q;
  wire            any  = |live;
  logic [IDX_W-1:0] win;

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (live[i]) win = IDX_W'(i);
  end

  wire [STAT_W-1:0] status = any ? STAT_W'(win) : STAT_W'(NSRC);
  wire stat_rd = rd_en && (rslot == S_STAT) && any;
  wire ack_wr  = wr_en && (wslot == S_ACK) && wr_data[0];

  wire [31:0] vec_n  = apply_op(wop, vec_q, wr_data);
  wire [31:0] ctrl_n = apply_op(wop, {srst_q, 31'b0}, wr_data);
  wire [31:0] en_n   = apply_op(wop, {29'b0, en_q[widx], 2'b0}, wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q    <= '0;
      srst_q   <= 1'b0;
      en_q     <= '0;
      in_svc_q <= 1'b0;
      cpu_irq  <= 1'b0;
    end else begin
      if (wr_en && wslot == S_VEC)  vec_q  <= vec_n;
      if (wr_en && wslot == S_CTRL) srst_q <= ctrl_n[31];
      if (wr_en && w_src)           en_q[widx] <= en_n[2];
      if (ack_wr)  in_svc_q <= 1'b0;
      if (stat_rd) in_svc_q <= 1'b1;
      if (srst_q) begin
        en_q     <= '0;
        in_svc_q <= 1'b0;
      end
      cpu_irq <= any && !in_svc_q;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rslot == S_VEC)       rd_data = vec_q;
    else if (rslot == S_CTRL) rd_data = {srst_q, 31'b0};
    else if (rslot == S_STAT) rd_data = 32'(status);
    else if (r_src)           rd_data = {29'b0, en_q[ridx], 2'b0};
  end

  // R4
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> $past(|(src_i & en_q)));
  // R3
  status_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(status) < NSRC) |-> src_i[win]);
  // R6
  in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc_q |=> !cpu_irq);
  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !stat_rd) |=> !in_svc_q);
  // R9
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (en_q == '0 && !in_svc_q));

endmodule

// File: tb/sim_irq_collector.sv
module sim_irq_collector;
  localparam int N = 128;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] src = '0;
  logic wr_en = 0, rd_en = 0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic cpu_irq;
  int checks = 0, fails = 0;

  irq_collector u0 (.clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .cpu_irq(cpu_irq));

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    #2 d = rd_data;
    @(negedge clk);
    rd_en = 0;
  endtask

  function automatic logic [11:0] sa(input int n, input int op);
    return 12'(32'h120 + 16 * n + 4 * op);
  endfunction

  initial begin
    logic [31:0] v;
    step(); step();
    rst_n = 1;
    step();
    // R10
    check("R10 irq", 32'(cpu_irq), 0);
    rd(12'h000, v); check("R10 vector", v, 0);
    rd(12'h020, v); check("R10 ctrl", v, 0);
    rd(12'h070, v); check("R10 status", v, N);
    rd(sa(0, 0), v); check("R10 src0", v, 0);
    rd(sa(N - 1, 0), v); check("R10 srcN", v, 0);

    // R1 vector aliases
    wr(12'h000, 32'h0000_00F0); rd(12'h000, v); check("R1 plain", v, 32'h0F0);
    wr(12'h004, 32'h0000_000F); rd(12'h000, v); check("R1 set", v, 32'h0FF);
    wr(12'h008, 32'h0000_00F0); rd(12'h000, v); check("R1 clear", v, 32'h00F);
    wr(12'h00C, 32'hA000_00FF); rd(12'h000, v); check("R1 toggle", v, 32'hA000_00F0);
    rd(12'h010, v); check("R7 ack reads 0", v, 0);

    for (int n = 0; n < N; n++) begin
      wr(sa(n, 1), 32'h4);
      rd(sa(n, 0), v); check("R2 enable readback", v, 4);
      step(); check("R5 irq idle", 32'(cpu_irq), 0);
      src[n] = 1'b1;
      #2 check("R5 irq before edge", 32'(cpu_irq), 0);
      step(); check("R5 irq after edge", 32'(cpu_irq), 1);
      rd(12'h070, v); check("R3 status", v, n);
      step(); check("R6 in service", 32'(cpu_irq), 0);
      step(); check("R6 still low", 32'(cpu_irq), 0);
      wr(12'h010 + 12'(4 * (n % 4)), 32'h1);
      step(); check("R7 ack returns irq", 32'(cpu_irq), 1);
      wr(sa(n, 2), 32'h4);
      step(); check("R4 masked irq", 32'(cpu_irq), 0);
      rd(12'h070, v); check("R4 masked status", v, N);
      src[n] = 1'b0;
    end

    for (int k = 0; k < 16; k++) begin
      int i, j, lo;
      i = k * 7;
      j = (k * 29 + 3) % N;
      if (i == j) j = (j + 1) % N;
      lo = (i < j) ? i : j;
      wr(sa(i, 0), 32'h4);
      wr(sa(j, 0), 32'h4);
      src[i] = 1'b1; src[j] = 1'b1;
      step();
      rd(12'h070, v); check("R3 lowest wins", v, lo);
      wr(sa(i, 3), 32'h4);
      wr(sa(j, 3), 32'h4);
      rd(sa(i, 0), v); check("R1 toggle enable off", v, 0);
      rd(12'h070, v); check("R4 none reported", v, N);
      src[i] = 1'b0; src[j] = 1'b0;
      wr(12'h010, 32'h1);
    end

    // R8 read and ack in the same cycle
    wr(sa(10, 1), 32'h4);
    src[10] = 1'b1;
    step(); step();
    check("R8 irq up", 32'(cpu_irq), 1);
    rd(12'h070, v); check("R8 status", v, 10);
    step();
    @(negedge clk);
    rd_en = 1; rd_addr = 12'h070; wr_en = 1; wr_addr = 12'h010; wr_data = 32'h1;
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    step(); check("R8 read wins", 32'(cpu_irq), 0);
    step(); check("R8 stays in service", 32'(cpu_irq), 0);
    wr(12'h010, 32'h1);
    step(); check("R8 lone ack", 32'(cpu_irq), 1);

    // R9 soft reset
    wr(sa(70, 1), 32'h4);
    src[70] = 1'b1;
    rd(12'h070, v);
    wr(12'h024, 32'h8000_0000);
    rd(12'h020, v); check("R9 bit reads back", v, 32'h8000_0000);
    rd(sa(10, 0), v); check("R9 enable cleared", v, 0);
    rd(sa(70, 0), v); check("R9 enable cleared 70", v, 0);
    wr(sa(5, 1), 32'h4);
    rd(sa(5, 0), v); check("R9 write discarded", v, 0);
    rd(12'h070, v); check("R9 status empty", v, N);
    step(); check("R9 irq low", 32'(cpu_irq), 0);
    wr(12'h028, 32'h8000_0000);
    rd(12'h020, v); check("R9 bit cleared", v, 0);
    rd(sa(10, 0), v); check("R9 enables stay clear", v, 0);
    wr(sa(10, 1), 32'h4);
    step(); step();
    check("R9 in-service cleared", 32'(cpu_irq), 1);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule